// File: doc/BRIEF.md
# Matrix Age Selector

This block picks, every cycle, the oldest entry from a set of candidates that raise an eligibility bit. Relative age is stored as an N by N bit matrix rather than as per-entry timestamps. A set bit at row i, column j means entry i was picked more recently than entry j. The candidate whose row has no set bit against any other candidate is the oldest, and it receives the grant.

The grant is combinational from the current eligibility vector and the stored matrix. On the following clock edge the granted entry k becomes the youngest. Every bit of row k is set, and every bit of column k is cleared, including the diagonal. The result is starvation-free, least-recently-served arbitration with no wide counters. With only two candidates, the matrix behaves as one toggling bit.

Top module: `age_select`

## Requirements
- R1: After reset every matrix bit is zero. When all entries are eligible, the first grant goes to entry 0.
- R2: `grant` is one-hot or zero and only ever names an eligible entry. `grantValid` is high exactly when at least one entry is eligible.
- R3: With no eligible entry, `grantValid` is low and `grant` is zero. The stored ages are left unchanged, so the next non-empty request is decided as if the idle cycles never happened.
- R4: Among the eligible entries, the grant goes to the one granted least recently. An entry never granted since reset counts as older than any entry that has been granted.
- R5: Among eligible entries that have never been granted since reset, the lowest index wins.
- R6: On the clock edge after a grant to entry k, entry k becomes the youngest of all entries: its row becomes all ones except the diagonal, and its column becomes all zeros.
- R7: An ineligible entry has no effect on which eligible entry is chosen, whatever its age.
- R8: With only entries 0 and 1 requesting every cycle, the grant alternates between them on every cycle.
- R9: The grant responds in the same cycle as the eligibility vector, and the age update takes effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset that clears the age matrix |
| eligible | input | NUM_ENTRIES | Bit i high when entry i competes this cycle |
| grant | output | NUM_ENTRIES | One-hot pick of the oldest eligible entry; bit i selects entry i |
| grantValid | output | 1 | High when `grant` names an entry |

## Verification
The grant for a given eligibility vector is due in the same cycle the vector is applied, before the next rising edge. The age change that this grant causes is due from that edge onward. The bench therefore drives `eligible` on the falling edge and samples `grant` and `grantValid` two nanoseconds later, in the same cycle. The effect of each update is judged only through the grant of the following cycle. The reference keeps, for each entry, the cycle number of its last grant. It chooses the smallest stamp, with ties going to the lowest index, and does not model the matrix at all.

// File: rtl/agesel_pkg.sv
package agesel_pkg;
  // Width of the index carried on the update strobe; supports up to 256 entries.
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             fire;  // a grant was issued this cycle
    logic [IDX_W-1:0] idx;   // which entry was granted
  } ageStrobe_t;
endpackage

// File: rtl/age_select_ctrl.sv
module age_select_ctrl
  import agesel_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NUM_ENTRIES-1:0]                 eligible,
  input  logic [NUM_ENTRIES-1:0][NUM_ENTRIES-1:0] ageRows,
  output logic [NUM_ENTRIES-1:0]                 grant,
  output logic                                   grantValid,
  output ageStrobe_t                             upd
);
  localparam logic [NUM_ENTRIES-1:0] LSB_ONE = NUM_ENTRIES'(1);

  // An eligible row with no set bit toward another eligible column has no
  // older competitor; the matrix guarantees at least one such row exists.
  logic [NUM_ENTRIES-1:0] rowClear;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_row
    assign rowClear[i] = eligible[i] & ~|(ageRows[i] & eligible);
  end

  // Ties among zero rows (entries never granted) go to the lowest index.
  assign grant      = rowClear & (~rowClear + LSB_ONE);
  assign grantValid = |eligible;

  always_comb begin
    upd      = '0;
    upd.fire = grantValid;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (grant[i]) upd.idx = IDX_W'(i);
    end
  end

  // R2: at most one entry granted, and only an eligible one
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
  p_grant_elig_r2: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~eligible) == '0);
  // R4: whenever someone competes, an oldest entry is found
  p_oldest_found_r4: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> $onehot(grant));
  // R3: nothing granted when nobody competes
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> (grant == '0));
endmodule

// File: rtl/age_select_dp.sv
module age_select_dp
  import agesel_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  ageStrobe_t                              upd,
  output logic [NUM_ENTRIES-1:0][NUM_ENTRIES-1:0] ageRows
);
  // ageQ[r][c] set: entry r was granted after entry c.
  logic [NUM_ENTRIES-1:0][NUM_ENTRIES-1:0] ageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ageQ <= '0;
    end else if (upd.fire) begin
      for (int r = 0; r < NUM_ENTRIES; r++) begin
        for (int c = 0; c < NUM_ENTRIES; c++) begin
          if (c == int'(upd.idx))      ageQ[r][c] <= 1'b0;
          else if (r == int'(upd.idx)) ageQ[r][c] <= 1'b1;
        end
      end
    end
  end

  assign ageRows = ageQ;

  for (genvar r = 0; r < NUM_ENTRIES; r++) begin : g_chk_r
    for (genvar c = 0; c < NUM_ENTRIES; c++) begin : g_chk_c
      if (r == c) begin : g_diag
        // R6: the column clear keeps the diagonal at zero
        p_diag_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
          !ageQ[r][c]);
      end else begin : g_off
        // R4: two entries can never both be younger than each other
        p_antisym_r4: assert property (@(posedge clk) disable iff (!rstN)
          !(ageQ[r][c] && ageQ[c][r]));
        // R6: granted row becomes all ones on the next edge
        p_row_set_r6: assert property (@(posedge clk) disable iff (!rstN)
          (upd.fire && upd.idx == IDX_W'(r)) |=> ageQ[r][c]);
        // R6: granted column becomes all zeros on the next edge
        p_col_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
          (upd.fire && upd.idx == IDX_W'(c)) |=> !ageQ[r][c]);
        // R3: idle cycles leave the ages untouched
        p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
          !upd.fire |=> $stable(ageQ[r][c]));
      end
    end
  end
endmodule

// File: rtl/age_select.sv
module age_select
  import agesel_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_ENTRIES-1:0] eligible,
  output logic [NUM_ENTRIES-1:0] grant,
  output logic                   grantValid
);
  ageStrobe_t                              upd;
  logic [NUM_ENTRIES-1:0][NUM_ENTRIES-1:0] ageRows;

  age_select_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .eligible   (eligible),
    .ageRows    (ageRows),
    .grant      (grant),
    .grantValid (grantValid),
    .upd        (upd)
  );

  age_select_dp #(.NUM_ENTRIES(NUM_ENTRIES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .upd     (upd),
    .ageRows (ageRows)
  );
endmodule

// File: tb/sim_age_select.sv
module sim_age_select;
  localparam int N = 8;

  typedef struct packed {
    logic         valid;
    logic [N-1:0] grant;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] eligible = '0;
  logic [N-1:0] grant;
  logic         grantValid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  expItem_t expQ[$];
  string    tagQ[$];

  // Reference: cycle stamp of each entry's last grant (0 = never granted).
  int stamp[N];
  int now = 0;

  age_select #(.NUM_ENTRIES(N)) u0 (
    .clk(clk), .rstN(rstN), .eligible(eligible),
    .grant(grant), .grantValid(grantValid)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [N-1:0] gotG, input logic gotV,
                       input logic [N-1:0] expG, input logic expV);
    checks++;
    if (gotG !== expG || gotV !== expV) begin
      failures++;
      $display("FAIL %s grant=%b valid=%b expected grant=%b valid=%b",
               tag, gotG, gotV, expG, expV);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Driver: apply eligibility on the falling edge, predict, push.
  task automatic drive(input logic [N-1:0] e, input string tag);
    expItem_t it;
    int best;
    @(negedge clk);
    eligible = e;
    it = '0;
    best = -1;
    for (int i = 0; i < N; i++) begin
      if (e[i] && (best < 0 || stamp[i] < stamp[best])) best = i;
    end
    if (best >= 0) begin
      it.valid = 1'b1;
      it.grant[best] = 1'b1;
      now++;
      stamp[best] = now;   // R6: granted entry becomes youngest
    end
    expQ.push_back(it);
    tagQ.push_back(tag);
  endtask

  // Monitor: R9, the grant is due in the same cycle, before the next edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t it;
        string t;
        it = expQ.pop_front();
        t  = tagQ.pop_front();
        check(t, grant, grantValid, it.grant, it.valid);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < N; i++) stamp[i] = 0;

    // R1: reset state, nobody eligible, then all eligible picks entry 0
    repeat (2) @(negedge clk);
    #2 check("R1 reset idle", grant, grantValid, '0, 1'b0);
    @(negedge clk);
    eligible = '1;
    #2 check("R1 reset tie", grant, grantValid, N'(1), 1'b1);
    @(negedge clk);
    eligible = '0;
    rstN = 1'b1;

    // R4 R5 R6: all eligible sweeps every index in order
    for (int k = 0; k < N; k++) drive('1, "R5 R6 all eligible");
    for (int k = 0; k < N; k++) drive('1, "R4 second round");

    // R3: idle cycles, then the order resumes unchanged
    for (int k = 0; k < 3; k++) drive('0, "R3 idle");
    drive('1, "R3 resume");
    drive('1, "R3 resume next");

    // R8: two requesters alternate
    for (int k = 0; k < 6; k++) drive(8'b0000_0011, "R8 two-entry alternation");

    // R7: old ineligible entries do not sway the choice
    drive(8'b1010_0100, "R7 masked");
    drive(8'b1010_0100, "R7 masked");
    drive(8'b0101_1000, "R7 masked other");
    drive(8'b1000_0000, "R7 single");
    drive(8'b1000_0001, "R7 pair");

    // R2 R4: pseudo-random eligibility
    lfsr = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[7:0], "R2 R4 random");
    end

    repeat (3) @(negedge clk);
    done = 1;
    finishRun();
  end
endmodule